// File: doc/BRIEF.md
# Palette-Indexed Raster Scan-Out Engine

This block produces a progressive raster from a frame store of 8-bit palette indices. A column counter runs on every pixel clock and steps a row counter each time it wraps. Together they sweep a frame that is larger than the visible area by a horizontal and a vertical blanking interval. In the visible area the two counters form a linear frame-store address, `row * H_ACT + col`. The index read there selects a 24-bit colour word from a lookup table. That word is split into red, green and blue intensities.

The frame store and the colour table each have their own host write port (address, data, strobe). Host writes go in on any cycle and never delay the display reads. The outputs are RGB, active-low horizontal and vertical sync, and a blanking flag. All of them are registered and aligned with one another.

The default geometry is small (32 by 24 visible) so that the memories stay small. A 640 by 480 raster is set through the parameters. The timing parameters are:

- `H_ACT`, `H_FP`, `H_SW`, `H_BP`: visible width, front porch, sync width and back porch of a line.
- `V_ACT`, `V_FP`, `V_SW`, `V_BP`: the same four quantities for the frame, counted in lines.

Top module: `pal_display`

## Requirements
- R1: While reset is high, and for the first two clocks after it is released, the outputs hold the idle state: `blank_o`=1, `hsync_n_o`=1, `vsync_n_o`=1, RGB=0.
- R2: Columns count 0 to H_ACT+H_FP+H_SW+H_BP-1 and then wrap. `hsync_n_o` is low for exactly H_SW columns per line, starting at column H_ACT+H_FP.
- R3: The row advances once per line, on the column wrap, and wraps after V_ACT+V_FP+V_SW+V_BP-1. `vsync_n_o` is low for exactly V_SW whole lines, starting at row V_ACT+V_FP. It changes only at the start of a line.
- R4: `blank_o` is high exactly when the column is at least H_ACT or the row is at least V_ACT.
- R5: While `blank_o` is high, all three colour outputs are zero, whatever the frame store and the table hold.
- R6: For a visible pixel, the outputs show `lut[fb[row*H_ACT+col]]`. In the 24-bit table word, red is bits 23:16, green is bits 15:8 and blue is bits 7:0.
- R7: The outputs for a counter position appear three clocks after that position. The first visible pixel after reset is presented after the third rising edge following reset release.
- R8: A frame-store write is seen by the next read of that address. A read of the same address in the same cycle as the write returns the old value.
- R9: A table write changes the colour of every later pixel that uses that index. Frame-store contents are not affected.
- R10: Host writes to both memories on every cycle do not alter sync or blanking timing or stall the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_we | input | 1 | Frame-store write strobe |
| fb_waddr | input | FB_AW | Frame-store write address (linear, row*H_ACT+col) |
| fb_wdata | input | IDX_W | Palette index to store |
| lut_we | input | 1 | Colour-table write strobe |
| lut_waddr | input | IDX_W | Colour-table entry to write |
| lut_wdata | input | 3*CH_W | Colour word: red high, green middle, blue low |
| red_o | output | CH_W | Red intensity |
| green_o | output | CH_W | Green intensity |
| blue_o | output | CH_W | Blue intensity |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| blank_o | output | 1 | High outside the visible area |

## Verification
The bench writes each frame-store location while that same location is being scanned. A design that forwarded the new data, or that used a wrong address, would show the wrong colour on exactly those pixels. It rewrites palette entries in the middle of a frame. This exposes a table read taken at the wrong pipeline stage, which shows as colours one pixel early or late. It also exposes pixels that were not masked during blanking. Every output is compared on every clock against a behavioural model. An off-by-one in a counter wrap, a sync edge or the three-cycle alignment therefore appears as a mismatch at the exact column or row where it occurs, including the first pixels after reset.

// File: rtl/pal_disp_pkg.sv
package pal_disp_pkg;
  typedef struct packed {
    logic hs_n;
    logic vs_n;
    logic blank;
  } scan_flags_t;

  localparam scan_flags_t FLAGS_IDLE = '{hs_n: 1'b1, vs_n: 1'b1, blank: 1'b1};
endpackage

// File: rtl/scan_timing.sv
module scan_timing
  import pal_disp_pkg::*;
#(
  parameter int H_ACT = 32,
  parameter int H_FP  = 2,
  parameter int H_SW  = 4,
  parameter int H_BP  = 2,
  parameter int V_ACT = 24,
  parameter int V_FP  = 1,
  parameter int V_SW  = 2,
  parameter int V_BP  = 1,
  localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP,
  localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP,
  localparam int CW    = $clog2(H_TOT),
  localparam int RW    = $clog2(V_TOT),
  localparam int AW    = $clog2(H_ACT * V_ACT)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] rd_addr,
  output scan_flags_t   flags
);
  localparam logic [CW-1:0] H_LAST_C = CW'(H_TOT - 1);
  localparam logic [RW-1:0] V_LAST_C = RW'(V_TOT - 1);
  localparam logic [CW-1:0] H_ACT_C  = CW'(H_ACT);
  localparam logic [RW-1:0] V_ACT_C  = RW'(V_ACT);
  localparam logic [CW-1:0] HS_BEG_C = CW'(H_ACT + H_FP);
  localparam logic [CW-1:0] HS_END_C = CW'(H_ACT + H_FP + H_SW);
  localparam logic [RW-1:0] VS_BEG_C = RW'(V_ACT + V_FP);
  localparam logic [RW-1:0] VS_END_C = RW'(V_ACT + V_FP + V_SW);

  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;
  logic          visible;

  // column runs every clock, row steps on column wrap
  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
      row_q <= '0;
    end else if (col_q == H_LAST_C) begin
      col_q <= '0;
      row_q <= (row_q == V_LAST_C) ? '0 : row_q + RW'(1);
    end else begin
      col_q <= col_q + CW'(1);
    end
  end

  always_comb begin
    visible     = (col_q < H_ACT_C) && (row_q < V_ACT_C);
    flags.blank = !visible;
    flags.hs_n  = !((col_q >= HS_BEG_C) && (col_q < HS_END_C));
    flags.vs_n  = !((row_q >= VS_BEG_C) && (row_q < VS_END_C));
    rd_addr     = visible ? AW'(int'(row_q) * H_ACT + int'(col_q)) : '0;
  end

  a_r2_col_in_range: assert property (@(posedge clk) disable iff (rst)
    col_q <= H_LAST_C);

  a_r3_row_steps_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (row_q != $past(row_q)) |-> ($past(col_q) == H_LAST_C));

  a_r3_vsync_at_line_start: assert property (@(posedge clk) disable iff (rst)
    (flags.vs_n != $past(flags.vs_n)) |-> (col_q == '0));

  // R4: sync pulses only ever fall inside blanking
  a_r4_sync_inside_blank: assert property (@(posedge clk) disable iff (rst)
    (!flags.hs_n || !flags.vs_n) |-> flags.blank);
endmodule

// File: rtl/dp_ram.sv
module dp_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // read-before-write on a shared address: the old word is returned
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pal_display.sv
module pal_display
  import pal_disp_pkg::*;
#(
  parameter int H_ACT = 32,
  parameter int H_FP  = 2,
  parameter int H_SW  = 4,
  parameter int H_BP  = 2,
  parameter int V_ACT = 24,
  parameter int V_FP  = 1,
  parameter int V_SW  = 2,
  parameter int V_BP  = 1,
  parameter int IDX_W = 8,
  parameter int CH_W  = 8,
  localparam int FB_AW = $clog2(H_ACT * V_ACT),
  localparam int COL_W = 3 * CH_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fb_we,
  input  logic [FB_AW-1:0] fb_waddr,
  input  logic [IDX_W-1:0] fb_wdata,
  input  logic             lut_we,
  input  logic [IDX_W-1:0] lut_waddr,
  input  logic [COL_W-1:0] lut_wdata,
  output logic [CH_W-1:0]  red_o,
  output logic [CH_W-1:0]  green_o,
  output logic [CH_W-1:0]  blue_o,
  output logic             hsync_n_o,
  output logic             vsync_n_o,
  output logic             blank_o
);
  localparam int FB_DEPTH  = H_ACT * V_ACT;
  localparam int LUT_DEPTH = 1 << IDX_W;

  logic [FB_AW-1:0] fb_raddr;
  logic [IDX_W-1:0] pix_idx;
  logic [COL_W-1:0] colour;
  scan_flags_t      flags_s0, flags_s1, flags_s2;

  scan_timing #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP)
  ) u_timing (
    .clk    (clk),
    .rst    (rst),
    .rd_addr(fb_raddr),
    .flags  (flags_s0)
  );

  dp_ram #(.DEPTH(FB_DEPTH), .WIDTH(IDX_W)) u_frame (
    .clk  (clk),
    .we   (fb_we),
    .waddr(fb_waddr),
    .wdata(fb_wdata),
    .raddr(fb_raddr),
    .rdata(pix_idx)
  );

  dp_ram #(.DEPTH(LUT_DEPTH), .WIDTH(COL_W)) u_palette (
    .clk  (clk),
    .we   (lut_we),
    .waddr(lut_waddr),
    .wdata(lut_wdata),
    .raddr(pix_idx),
    .rdata(colour)
  );

  // timing flags ride alongside the two memory reads
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_s1 <= FLAGS_IDLE;
      flags_s2 <= FLAGS_IDLE;
    end else begin
      flags_s1 <= flags_s0;
      flags_s2 <= flags_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      red_o     <= '0;
      green_o   <= '0;
      blue_o    <= '0;
      hsync_n_o <= 1'b1;
      vsync_n_o <= 1'b1;
      blank_o   <= 1'b1;
    end else begin
      hsync_n_o <= flags_s2.hs_n;
      vsync_n_o <= flags_s2.vs_n;
      blank_o   <= flags_s2.blank;
      if (flags_s2.blank) begin
        red_o   <= '0;
        green_o <= '0;
        blue_o  <= '0;
      end else begin
        red_o   <= colour[3*CH_W-1:2*CH_W];
        green_o <= colour[2*CH_W-1:CH_W];
        blue_o  <= colour[CH_W-1:0];
      end
    end
  end

  a_r5_dark_in_blank: assert property (@(posedge clk) disable iff (rst)
    blank_o |-> (red_o == '0 && green_o == '0 && blue_o == '0));

  // R4: a visible pixel never coincides with an active sync output
  a_r4_visible_sync_idle: assert property (@(posedge clk) disable iff (rst)
    !blank_o |-> (hsync_n_o && vsync_n_o));
endmodule

// File: tb/test_pal_display.sv
module test_pal_display;
  localparam int CLK_PERIOD = 10;
  localparam int H_ACT = 32, H_FP = 2, H_SW = 4, H_BP = 2;
  localparam int V_ACT = 24, V_FP = 1, V_SW = 2, V_BP = 1;
  localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP;
  localparam int FRAME = H_TOT * V_TOT;
  localparam int FB_DEPTH = H_ACT * V_ACT;
  localparam int FB_AW = $clog2(FB_DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fb_we = 1'b0;
  logic [FB_AW-1:0] fb_waddr = '0;
  logic [7:0] fb_wdata = '0;
  logic lut_we = 1'b0;
  logic [7:0] lut_waddr = '0;
  logic [23:0] lut_wdata = '0;
  logic [7:0] red_o, green_o, blue_o;
  logic hsync_n_o, vsync_n_o, blank_o;

  pal_display i_pal_display (
    .clk(clk), .rst(rst),
    .fb_we(fb_we), .fb_waddr(fb_waddr), .fb_wdata(fb_wdata),
    .lut_we(lut_we), .lut_waddr(lut_waddr), .lut_wdata(lut_wdata),
    .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
    .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o), .blank_o(blank_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string phase = "";

  // behavioural reference
  int fb_m  [FB_DEPTH];
  int lut_m [256];
  int mcol = 0, mrow = 0, edges = 0;
  int q_vis [$];       // expected outputs queued per edge
  int q_hs  [$], q_vs [$], q_bl [$], q_idx [$];
  int exp_rgb = 0, exp_hs = 1, exp_vs = 1, exp_bl = 1;
  int pend_col = 0, pend_ok = 0, pend_hs = 1, pend_vs = 1, pend_bl = 1;

  initial begin
    for (int i = 0; i < FB_DEPTH; i++) fb_m[i] = 0;
    for (int i = 0; i < 256; i++) lut_m[i] = 0;
  end

  always @(posedge clk) begin
    if (rst) begin
      mcol = 0; mrow = 0; edges = 0;
      q_hs.delete(); q_vs.delete(); q_bl.delete(); q_idx.delete();
      pend_ok = 0;
      exp_rgb = 0; exp_hs = 1; exp_vs = 1; exp_bl = 1;
    end else begin
      // output of this edge: the entry looked up in the palette last edge
      if (pend_ok != 0) begin
        exp_bl = pend_bl; exp_hs = pend_hs; exp_vs = pend_vs;
        exp_rgb = (pend_bl != 0) ? 0 : pend_col;
      end else begin
        exp_rgb = 0; exp_hs = 1; exp_vs = 1; exp_bl = 1;
      end
      // palette lookup happens one edge after the frame-store read
      pend_ok = 0;
      if (q_idx.size() > 0) begin
        pend_col = lut_m[q_idx.pop_front()];
        pend_bl = q_bl.pop_front(); pend_hs = q_hs.pop_front(); pend_vs = q_vs.pop_front();
        pend_ok = 1;
      end
      begin
        int vis;
        vis = (mcol < H_ACT && mrow < V_ACT) ? 1 : 0;
        q_bl.push_back(1 - vis);
        q_hs.push_back((mcol >= H_ACT + H_FP && mcol < H_ACT + H_FP + H_SW) ? 0 : 1);
        q_vs.push_back((mrow >= V_ACT + V_FP && mrow < V_ACT + V_FP + V_SW) ? 0 : 1);
        q_idx.push_back(vis != 0 ? fb_m[mrow * H_ACT + mcol] : fb_m[0]);
      end
      mcol = mcol + 1;
      if (mcol == H_TOT) begin
        mcol = 0;
        mrow = (mrow == V_TOT - 1) ? 0 : mrow + 1;
      end
      edges = edges + 1;
    end
    if (fb_we) fb_m[fb_waddr] = fb_wdata;
    if (lut_we) lut_m[lut_waddr] = lut_wdata;
  end

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h (row %0d col %0d)", req, what, act, expv, mrow, mcol);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // compare every output at each falling edge
  always @(negedge clk) begin
    if (!done) begin
      string t_rgb, t_bl, t_hs, t_vs;
      bit early;
      early = rst || edges < 2;
      t_bl  = early ? "R1" : (phase == "R10" ? "R10" : "R4");
      t_hs  = early ? "R1" : (phase == "R10" ? "R10" : "R2");
      t_vs  = early ? "R1" : (phase == "R10" ? "R10" : "R3");
      t_rgb = early ? "R1" : (exp_bl != 0 ? "R5" : (phase == "" ? "R6" : phase));
      check(t_bl, "blank", int'(blank_o), exp_bl);
      check(t_hs, "hsync_n", int'(hsync_n_o), exp_hs);
      check(t_vs, "vsync_n", int'(vsync_n_o), exp_vs);
      check(t_rgb, "rgb", int'({red_o, green_o, blue_o}), exp_rgb);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int first_vis;
    int lf;
    first_vis = -1;
    lf = 32'h1ace;
    repeat (2) @(negedge clk);
    // load the palette and frame store under reset (R1 checks run meanwhile)
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      lut_we = 1'b1; lut_waddr = 8'(i);
      lut_wdata = {8'(i), 8'(255 - i), 8'(i ^ 'h5a)};
    end
    @(negedge clk); lut_we = 1'b0;
    for (int a = 0; a < FB_DEPTH; a++) begin
      @(negedge clk);
      fb_we = 1'b1; fb_waddr = FB_AW'(a); fb_wdata = 8'(a * 37 + 11);
    end
    @(negedge clk); fb_we = 1'b0; rst = 1'b0;
    // R7: first visible pixel after the third edge following release
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (!blank_o && first_vis < 0) first_vis = k;
    end
    check("R7", "first visible edge", first_vis, 3);
    repeat (FRAME) @(negedge clk);

    // R9: palette rewritten while the frame is being scanned
    phase = "R9";
    for (int c = 0; c < FRAME; c++) begin
      @(negedge clk);
      lut_we = 1'b1; lut_waddr = 8'(c);
      lut_wdata = {8'(c * 3 + 1), 8'(c ^ 'hc3), 8'(200 - c)};
    end
    @(negedge clk); lut_we = 1'b0;

    // R8: each pixel overwritten in the very cycle it is read
    phase = "R8";
    for (int c = 0; c < FRAME; c++) begin
      @(negedge clk);
      fb_we = 1'b1;
      fb_waddr = (mcol < H_ACT && mrow < V_ACT) ? FB_AW'(mrow * H_ACT + mcol) : '0;
      fb_wdata = 8'(c ^ 'ha5);
    end
    @(negedge clk); fb_we = 1'b0;
    repeat (FRAME) @(negedge clk);

    // R10: both memories written on every cycle
    phase = "R10";
    for (int c = 0; c < FRAME; c++) begin
      @(negedge clk);
      lf = (lf >> 1) ^ ((lf & 1) != 0 ? 32'hb400 : 0);
      fb_we = 1'b1; fb_waddr = FB_AW'((lf * 7) % FB_DEPTH); fb_wdata = 8'(lf);
      lut_we = 1'b1; lut_waddr = 8'(lf >> 3); lut_wdata = 24'(lf * 2654435);
    end
    @(negedge clk); fb_we = 1'b0; lut_we = 1'b0;
    phase = "";
    repeat (FRAME + 4) @(negedge clk);
    finish_run();
  end
endmodule